// File: doc/BRIEF.md
# Register-Typed Packed SIMD ALU

This block is the integer datapath of a small packed SIMD unit that works inside 32-bit general registers. How a 32-bit word is split into lanes is not taken from the opcode. It comes from the register numbers: the destination index selects the lane width and the signedness, and the source indices must agree with it on width. A 4-bit function code selects one operation from this set: add, subtract, halving add, halving subtract, minimum, maximum, and three lane compares.

A 2-bit mode field on each operation chooses between two things. It can run unmasked under the global saturation setting, or unmasked with saturation forced on for that operation alone. It can also merge under the predicate value, taken as is or inverted. The surrounding pipeline supplies several values with the operation: the operand values, the predicate word (the content of register 1) and the current content of the destination register. The block returns the merged word one clock later. A saturation that happens in an enabled lane sets a sticky flag, and the flag holds until it is cleared. A register combination that cannot be typed consistently is reported as illegal, and the destination value is passed through unchanged.

Top module: `bank_simd_alu`

## Requirements
- R1: The lane type follows the destination index. Indices 2..7 give four signed 8-bit lanes. Indices 8..15 give four unsigned 8-bit lanes. Indices 16..23 give two signed 16-bit lanes. Indices 24..29 give two unsigned 16-bit lanes. Indices 30..31 give one signed 32-bit lane. Lane k occupies bits [k*W+W-1 : k*W].
- R2: A source index of 0 reads as zero whatever value is on its operand port. It is legal with any lane width.
- R3: Function 0 adds and function 1 subtracts per lane. With mode 0 (encoding 00) and the global saturation enable low, the result wraps modulo 2^W.
- R4: Add and subtract saturate when mode is 1 (encoding 01), or when the global enable is high and the mode is not 1. A saturating lane clamps to the minimum or maximum of its type.
- R5: Function 2 is a halving add and function 3 is a halving subtract. The result is the W+1-bit exact sum or difference shifted right by one, arithmetically for signed lanes. These never saturate.
- R6: Function 4 gives the lane minimum and function 5 gives the lane maximum. Both follow the lane's signedness.
- R7: Function 6 compares for equality and function 7 compares for greater-than. Function 8 compares for less-or-equal and is produced as the inverse of greater-than. A lane whose compare is true is written as all ones; a lane whose compare is false is written as all zeros.
- R8: Mode 2 (encoding 10) enables a lane when bit 0 of the same lane of the predicate is 1. Mode 3 (encoding 11) enables a lane when that bit is 0. A disabled lane keeps the old destination value. Modes 2 and 3 use the global saturation enable.
- R9: The sticky flag is set by a legal operation in which an enabled lane saturated. It stays set until sat_clear is high, and sat_clear takes priority over a set in the same cycle.
- R10: The illegal output is raised for any of these conditions, and the result is then the old destination value with the sticky flag untouched:
  - the destination index is 0 or 1;
  - a source index is 1;
  - a non-zero source index whose width differs from the destination's width (this includes pairing 30/31 with an 8-bit or 16-bit register);
  - a function code above 8.
- R11: After reset, result, out_valid, illegal and the sticky flag are 0. An operation presented with in_valid at a rising edge appears on result, illegal and out_valid right after that edge. The result holds until the next operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| func | input | 4 | Operation code (0..8) |
| mode | input | 2 | Saturation / predicate mode |
| rd_idx | input | 5 | Destination register index |
| rs1_idx | input | 5 | First source register index |
| rs2_idx | input | 5 | Second source register index |
| opa | input | 32 | First source value |
| opb | input | 32 | Second source value |
| pred | input | 32 | Predicate register value |
| old_dst | input | 32 | Current destination value |
| sat_global | input | 1 | Global saturation enable |
| sat_clear | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Result valid |
| result | output | 32 | Merged result |
| illegal | output | 1 | Operation was illegal |
| sat_sticky | output | 1 | Sticky saturation flag |

## Verification
Each operation's result, illegal flag and out_valid are due at the first rising edge after the edge that takes in_valid, which is one register stage. The sticky flag changes at the same edge, and so does a clear. Each bench task drives its inputs on a falling edge and drops in_valid on the next falling edge. It then reads the outputs at that point, half a period after the capturing edge. The timing test also checks that out_valid falls one cycle later and that result holds.

// File: rtl/simd_pkg.sv
package simd_pkg;

    localparam int XLEN    = 32;
    localparam int IDX_W   = 5;
    localparam int FUNC_W  = 4;
    localparam int BYTES   = XLEN / 8;
    localparam int LANES8  = XLEN / 8;
    localparam int LANES16 = XLEN / 16;
    localparam int LANES32 = XLEN / 32;

    typedef enum logic [FUNC_W-1:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_HADD = 4'd2,
        OP_HSUB = 4'd3,
        OP_MIN  = 4'd4,
        OP_MAX  = 4'd5,
        OP_CEQ  = 4'd6,
        OP_CGT  = 4'd7,
        OP_CLE  = 4'd8
    } alu_op_e;

    localparam logic [FUNC_W-1:0] OP_LAST = 4'd8;

    typedef enum logic [1:0] {
        MM_PLAIN = 2'b00,
        MM_FORCE = 2'b01,
        MM_MASK  = 2'b10,
        MM_NMASK = 2'b11
    } mm_e;

    typedef enum logic [1:0] {
        LW_8    = 2'd0,
        LW_16   = 2'd1,
        LW_32   = 2'd2,
        LW_NONE = 2'd3
    } lane_w_e;

    typedef struct packed {
        lane_w_e width;
        logic    sgn;
        alu_op_e op;
        logic    sat_en;
        logic    use_mask;
        logic    inv_mask;
        logic    zero_a;
        logic    zero_b;
        logic    illegal;
    } dec_t;

    function automatic lane_w_e bank_width(input logic [IDX_W-1:0] idx);
        if (idx < 5'd2)       return LW_NONE;
        else if (idx < 5'd16) return LW_8;
        else if (idx < 5'd30) return LW_16;
        else                  return LW_32;
    endfunction

    function automatic logic bank_signed(input logic [IDX_W-1:0] idx);
        return (idx < 5'd8) || (idx >= 5'd16 && idx < 5'd24) || (idx >= 5'd30);
    endfunction

endpackage

// File: rtl/simd_decode.sv
module simd_decode
    import simd_pkg::*;
(
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  rs1_idx,
    input  logic [IDX_W-1:0]  rs2_idx,
    input  logic [FUNC_W-1:0] func,
    input  logic [1:0]        mode,
    input  logic              sat_global,
    output dec_t              dec
);
    lane_w_e wd, w1, w2;
    logic    bad_src;

    always_comb begin
        wd = bank_width(rd_idx);
        w1 = bank_width(rs1_idx);
        w2 = bank_width(rs2_idx);
        bad_src = (rs1_idx == 5'd1) || (rs2_idx == 5'd1)
               || ((rs1_idx != 5'd0) && (w1 != wd))
               || ((rs2_idx != 5'd0) && (w2 != wd));

        dec          = '0;
        dec.width    = wd;
        dec.sgn      = bank_signed(rd_idx);
        dec.op       = alu_op_e'(func);
        dec.sat_en   = (mode == MM_FORCE) || sat_global;
        dec.use_mask = (mode == MM_MASK) || (mode == MM_NMASK);
        dec.inv_mask = (mode == MM_NMASK);
        dec.zero_a   = (rs1_idx == 5'd0);
        dec.zero_b   = (rs2_idx == 5'd0);
        dec.illegal  = (wd == LW_NONE) || bad_src || (func > OP_LAST);
    end
endmodule

// File: rtl/simd_lane.sv
module simd_lane
    import simd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sgn,
    input  alu_op_e      op,
    input  logic         sat_en,
    output logic [W-1:0] res,
    output logic         sat
);
    localparam logic [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};

    logic [W:0] ea, eb, sum, dif;
    logic       ovf_add, ovf_sub, gt, eq;
    logic [W-1:0] clamp_add, clamp_sub;

    always_comb begin
        ea  = {sgn & a[W-1], a};
        eb  = {sgn & b[W-1], b};
        sum = ea + eb;
        dif = ea - eb;
        ovf_add = sgn ? (sum[W] != sum[W-1]) : sum[W];
        ovf_sub = sgn ? (dif[W] != dif[W-1]) : dif[W];
        clamp_add = sgn ? (sum[W] ? S_MIN : S_MAX) : '1;
        clamp_sub = sgn ? (dif[W] ? S_MIN : S_MAX) : '0;
        gt  = $signed(ea) > $signed(eb);
        eq  = (a == b);
        sat = 1'b0;
        unique case (op)
            OP_ADD: begin
                sat = sat_en & ovf_add;
                res = sat ? clamp_add : sum[W-1:0];
            end
            OP_SUB: begin
                sat = sat_en & ovf_sub;
                res = sat ? clamp_sub : dif[W-1:0];
            end
            OP_HADD: res = sum[W:1];
            OP_HSUB: res = dif[W:1];
            OP_MIN:  res = gt ? b : a;
            OP_MAX:  res = gt ? a : b;
            OP_CEQ:  res = {W{eq}};
            OP_CGT:  res = {W{gt}};
            OP_CLE:  res = {W{~gt}};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/simd_mask_merge.sv
module simd_mask_merge
    import simd_pkg::*;
(
    input  lane_w_e             width,
    input  logic                use_mask,
    input  logic                inv_mask,
    input  logic [XLEN-1:0]     pred,
    input  logic [XLEN-1:0]     fresh,
    input  logic [XLEN-1:0]     old_dst,
    input  logic [LANES8-1:0]   sat8,
    input  logic [LANES16-1:0]  sat16,
    input  logic [LANES32-1:0]  sat32,
    output logic [XLEN-1:0]     merged,
    output logic                sat_hit
);
    logic [XLEN-1:0]  mword;
    logic [BYTES-1:0] byte_en, byte_sat;
    logic             unused_bits;

    assign mword = inv_mask ? ~pred : pred;

    for (genvar j = 0; j < BYTES; j++) begin : g_byte
        always_comb begin
            unique case (width)
                LW_8: begin
                    byte_en[j]  = mword[8*j];
                    byte_sat[j] = sat8[j];
                end
                LW_16: begin
                    byte_en[j]  = mword[16*(j/2)];
                    byte_sat[j] = sat16[j/2];
                end
                default: begin
                    byte_en[j]  = mword[32*(j/4)];
                    byte_sat[j] = sat32[j/4];
                end
            endcase
            if (!use_mask) byte_en[j] = 1'b1;
        end
        assign merged[8*j +: 8] = byte_en[j] ? fresh[8*j +: 8] : old_dst[8*j +: 8];
    end

    assign sat_hit     = |(byte_en & byte_sat);
    assign unused_bits = ^mword;
endmodule

// File: rtl/bank_simd_alu.sv
module bank_simd_alu
    import simd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [FUNC_W-1:0] func,
    input  logic [1:0]        mode,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [IDX_W-1:0]  rs1_idx,
    input  logic [IDX_W-1:0]  rs2_idx,
    input  logic [XLEN-1:0]   opa,
    input  logic [XLEN-1:0]   opb,
    input  logic [XLEN-1:0]   pred,
    input  logic [XLEN-1:0]   old_dst,
    input  logic              sat_global,
    input  logic              sat_clear,
    output logic              out_valid,
    output logic [XLEN-1:0]   result,
    output logic              illegal,
    output logic              sat_sticky
);
    dec_t              dec;
    logic [XLEN-1:0]   va, vb, r8, r16, r32, fresh, merged;
    logic [LANES8-1:0]  s8;
    logic [LANES16-1:0] s16;
    logic [LANES32-1:0] s32;
    logic              sat_hit;

    simd_decode u_dec (
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .func(func), .mode(mode), .sat_global(sat_global), .dec(dec)
    );

    assign va = dec.zero_a ? '0 : opa;
    assign vb = dec.zero_b ? '0 : opb;

    for (genvar i = 0; i < LANES8; i++) begin : g_l8
        simd_lane #(.W(8)) u_lane (
            .a(va[8*i +: 8]), .b(vb[8*i +: 8]), .sgn(dec.sgn), .op(dec.op),
            .sat_en(dec.sat_en), .res(r8[8*i +: 8]), .sat(s8[i])
        );
    end
    for (genvar i = 0; i < LANES16; i++) begin : g_l16
        simd_lane #(.W(16)) u_lane (
            .a(va[16*i +: 16]), .b(vb[16*i +: 16]), .sgn(dec.sgn), .op(dec.op),
            .sat_en(dec.sat_en), .res(r16[16*i +: 16]), .sat(s16[i])
        );
    end
    for (genvar i = 0; i < LANES32; i++) begin : g_l32
        simd_lane #(.W(32)) u_lane (
            .a(va[32*i +: 32]), .b(vb[32*i +: 32]), .sgn(dec.sgn), .op(dec.op),
            .sat_en(dec.sat_en), .res(r32[32*i +: 32]), .sat(s32[i])
        );
    end

    always_comb begin
        unique case (dec.width)
            LW_8:    fresh = r8;
            LW_16:   fresh = r16;
            default: fresh = r32;
        endcase
    end

    simd_mask_merge u_merge (
        .width(dec.width), .use_mask(dec.use_mask), .inv_mask(dec.inv_mask),
        .pred(pred), .fresh(fresh), .old_dst(old_dst),
        .sat8(s8), .sat16(s16), .sat32(s32),
        .merged(merged), .sat_hit(sat_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            result     <= '0;
            illegal    <= 1'b0;
            sat_sticky <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result  <= dec.illegal ? old_dst : merged;
                illegal <= dec.illegal;
            end
            if (sat_clear)
                sat_sticky <= 1'b0;
            else if (in_valid && !dec.illegal && sat_hit)
                sat_sticky <= 1'b1;
        end
    end
endmodule

// File: rtl/bank_simd_alu_chk.sv
module bank_simd_alu_chk
    import simd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [FUNC_W-1:0] func,
    input logic [1:0]        mode,
    input logic [IDX_W-1:0]  rd_idx,
    input logic [XLEN-1:0]   pred,
    input logic [XLEN-1:0]   old_dst,
    input logic              sat_clear,
    input logic              out_valid,
    input logic [XLEN-1:0]   result,
    input logic              illegal,
    input logic              sat_sticky
);
    // R11
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R11
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R10
    illegal_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && illegal) |-> (result == $past(old_dst)));
    // R9
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sat_sticky && !sat_clear) |=> sat_sticky);
    // R9
    sticky_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sat_clear |=> !sat_sticky);
    // R9
    sticky_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sat_sticky) |-> $past(in_valid));
    // R8
    mask_none_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(mode) == MM_MASK && $past(pred) == '0)
        |-> (result == $past(old_dst)));
    // R7
    cmp_word_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !illegal && $past(rd_idx) >= 5'd30 && !$past(mode[1])
         && $past(func) >= OP_CEQ) |-> ((result == '0) || (result == '1)));
endmodule

bind bank_simd_alu bank_simd_alu_chk chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .func(func), .mode(mode),
    .rd_idx(rd_idx), .pred(pred), .old_dst(old_dst), .sat_clear(sat_clear),
    .out_valid(out_valid), .result(result), .illegal(illegal),
    .sat_sticky(sat_sticky)
);

// File: tb/bank_simd_alu_tb_top.sv
`timescale 1ns/1ps
module bank_simd_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [3:0]  func = '0;
    logic [1:0]  mode = '0;
    logic [4:0]  rd_idx = '0, rs1_idx = '0, rs2_idx = '0;
    logic [31:0] opa = '0, opb = '0, pred = '0, old_dst = '0;
    logic        sat_global = 1'b0, sat_clear = 1'b0;
    logic        out_valid, illegal, sat_sticky;
    logic [31:0] result;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    bank_simd_alu dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .func(func), .mode(mode),
        .rd_idx(rd_idx), .rs1_idx(rs1_idx), .rs2_idx(rs2_idx),
        .opa(opa), .opb(opb), .pred(pred), .old_dst(old_dst),
        .sat_global(sat_global), .sat_clear(sat_clear),
        .out_valid(out_valid), .result(result), .illegal(illegal),
        .sat_sticky(sat_sticky)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic issue(input logic [3:0] f, input logic [1:0] m,
                         input logic [4:0] d, input logic [4:0] s1, input logic [4:0] s2,
                         input logic [31:0] a, input logic [31:0] b,
                         input logic [31:0] p, input logic [31:0] o, input logic g);
        @(negedge clk);
        func = f; mode = m; rd_idx = d; rs1_idx = s1; rs2_idx = s2;
        opa = a; opb = b; pred = p; old_dst = o; sat_global = g;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        sat_clear = 1'b1;
        @(negedge clk);
        sat_clear = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 reset result", result, 32'h0);
        chk("R11 reset out_valid", {31'b0, out_valid}, 32'h0);
        chk("R11 reset illegal", {31'b0, illegal}, 32'h0);
        chk("R11 reset sticky", {31'b0, sat_sticky}, 32'h0);
    endtask

    task automatic t_wrap_add();
        issue(4'd0, 2'b00, 5'd2, 5'd3, 5'd4, 32'h7F01FF80, 32'h01010180, 0, 0, 1'b0);
        chk("R1 R3 s8 wrap add", result, 32'h80020000);
        chk("R3 valid", {31'b0, out_valid}, 32'h1);
        chk("R3 no sticky", {31'b0, sat_sticky}, 32'h0);
        issue(4'd1, 2'b00, 5'd24, 5'd25, 5'd26, 32'h00000001, 32'h00010002, 0, 0, 1'b0);
        chk("R1 R3 u16 wrap sub", result, 32'hFFFFFFFF);
    endtask

    task automatic t_saturate();
        issue(4'd0, 2'b01, 5'd2, 5'd3, 5'd4, 32'h7F01FF80, 32'h01010180, 0, 0, 1'b0);
        chk("R4 s8 forced sat add", result, 32'h7F020080);
        chk("R9 sticky set", {31'b0, sat_sticky}, 32'h1);
        issue(4'd0, 2'b00, 5'd2, 5'd3, 5'd4, 32'h01010101, 32'h01010101, 0, 0, 1'b0);
        chk("R9 sticky holds", {31'b0, sat_sticky}, 32'h1);
        pulse_clear();
        chk("R9 sticky cleared", {31'b0, sat_sticky}, 32'h0);
        issue(4'd1, 2'b00, 5'd8, 5'd9, 5'd10, 32'h10FF0005, 32'h20010003, 0, 0, 1'b1);
        chk("R4 u8 global sat sub", result, 32'h00FE0002);
        issue(4'd0, 2'b00, 5'd12, 5'd13, 5'd14, 32'hF0000000, 32'h20000000, 0, 0, 1'b1);
        chk("R4 u8 global sat add", result, 32'hFF000000);
        // set and clear in the same cycle: clear wins
        @(negedge clk);
        func = 4'd0; mode = 2'b01; rd_idx = 5'd30; rs1_idx = 5'd31; rs2_idx = 5'd30;
        opa = 32'h7FFFFFFF; opb = 32'h00000001; sat_global = 1'b0;
        in_valid = 1'b1; sat_clear = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; sat_clear = 1'b0;
        chk("R4 s32 sat add", result, 32'h7FFFFFFF);
        chk("R9 clear priority", {31'b0, sat_sticky}, 32'h0);
    endtask

    task automatic t_halving();
        issue(4'd2, 2'b01, 5'd16, 5'd17, 5'd18, 32'h7FFF8000, 32'h7FFFFFFF, 0, 0, 1'b0);
        chk("R5 s16 halving add", result, 32'h7FFFBFFF);
        chk("R5 halving never saturates", {31'b0, sat_sticky}, 32'h0);
        issue(4'd3, 2'b00, 5'd24, 5'd27, 5'd28, 32'h0009FFFF, 32'h00030001, 0, 0, 1'b0);
        chk("R5 u16 halving sub", result, 32'h00037FFF);
    endtask

    task automatic t_minmax();
        issue(4'd4, 2'b00, 5'd30, 5'd31, 5'd30, 32'hFFFFFFFE, 32'h00000005, 0, 0, 1'b0);
        chk("R6 s32 min", result, 32'hFFFFFFFE);
        issue(4'd5, 2'b00, 5'd8, 5'd9, 5'd11, 32'h80017F00, 32'h7F02FF01, 0, 0, 1'b0);
        chk("R6 u8 max", result, 32'h8002FF01);
        issue(4'd5, 2'b00, 5'd2, 5'd3, 5'd4, 32'h80017F00, 32'h7F02FF01, 0, 0, 1'b0);
        chk("R6 s8 max", result, 32'h7F027F01);
    endtask

    task automatic t_compare();
        issue(4'd7, 2'b00, 5'd24, 5'd25, 5'd26, 32'h80000001, 32'h7FFF0001, 0, 0, 1'b0);
        chk("R7 u16 cgt", result, 32'hFFFF0000);
        issue(4'd8, 2'b00, 5'd24, 5'd25, 5'd26, 32'h80000001, 32'h7FFF0001, 0, 0, 1'b0);
        chk("R7 u16 cle", result, 32'h0000FFFF);
        issue(4'd7, 2'b00, 5'd16, 5'd17, 5'd18, 32'h80000001, 32'h7FFF0001, 0, 0, 1'b0);
        chk("R7 s16 cgt", result, 32'h00000000);
        issue(4'd6, 2'b00, 5'd2, 5'd3, 5'd4, 32'h11223344, 32'h11003344, 0, 0, 1'b0);
        chk("R7 s8 ceq", result, 32'hFF00FFFF);
    endtask

    task automatic t_zero_src();
        issue(4'd0, 2'b00, 5'd3, 5'd4, 5'd0, 32'h01020304, 32'hFFFFFFFF, 0, 0, 1'b0);
        chk("R2 zero source", result, 32'h01020304);
        chk("R2 zero source legal", {31'b0, illegal}, 32'h0);
    endtask

    task automatic t_mask();
        issue(4'd0, 2'b10, 5'd2, 5'd3, 5'd4, 32'h01010101, 32'h01010101, 32'h00010100, 32'hAABBCCDD, 1'b0);
        chk("R8 true mask", result, 32'hAA0202DD);
        issue(4'd0, 2'b11, 5'd2, 5'd3, 5'd4, 32'h01010101, 32'h01010101, 32'h00010100, 32'hAABBCCDD, 1'b0);
        chk("R8 inverted mask", result, 32'h02BBCC02);
        issue(4'd1, 2'b10, 5'd16, 5'd17, 5'd18, 32'h00100010, 32'h00010001, 32'h00000001, 32'h55556666, 1'b0);
        chk("R8 s16 mask", result, 32'h5555000F);
        issue(4'd0, 2'b10, 5'd2, 5'd3, 5'd4, 32'h7F7F0000, 32'h01010000, 32'h00000101, 32'h12345678, 1'b1);
        chk("R8 masked sat lanes", result, 32'h12340000);
        chk("R9 disabled lane no sticky", {31'b0, sat_sticky}, 32'h0);
    endtask

    task automatic t_illegal();
        issue(4'd0, 2'b01, 5'd16, 5'd3, 5'd17, 32'h7FFF7FFF, 32'h7FFF7FFF, 0, 32'hCAFEF00D, 1'b0);
        chk("R10 width mix result", result, 32'hCAFEF00D);
        chk("R10 width mix flag", {31'b0, illegal}, 32'h1);
        chk("R10 sticky untouched", {31'b0, sat_sticky}, 32'h0);
        issue(4'd0, 2'b00, 5'd30, 5'd2, 5'd3, 32'h1, 32'h1, 0, 32'h0BADBEEF, 1'b0);
        chk("R10 reg30 with 8-bit", {31'b0, illegal}, 32'h1);
        issue(4'd0, 2'b00, 5'd2, 5'd1, 5'd3, 32'h1, 32'h1, 0, 32'h0, 1'b0);
        chk("R10 source 1", {31'b0, illegal}, 32'h1);
        issue(4'd15, 2'b00, 5'd2, 5'd3, 5'd4, 32'h1, 32'h1, 0, 32'h0, 1'b0);
        chk("R10 bad func", {31'b0, illegal}, 32'h1);
        issue(4'd0, 2'b00, 5'd0, 5'd3, 5'd4, 32'h1, 32'h1, 0, 32'h77, 1'b0);
        chk("R10 dest 0", {31'b0, illegal}, 32'h1);
        chk("R10 dest 0 result", result, 32'h77);
    endtask

    task automatic t_timing();
        issue(4'd0, 2'b00, 5'd30, 5'd31, 5'd0, 32'h00001234, 32'h0, 0, 0, 1'b0);
        chk("R11 result one cycle", result, 32'h00001234);
        @(negedge clk);
        chk("R11 valid drops", {31'b0, out_valid}, 32'h0);
        chk("R11 result holds", result, 32'h00001234);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_wrap_add();
        t_saturate();
        t_halving();
        t_minmax();
        t_compare();
        t_zero_src();
        t_mask();
        t_illegal();
        t_timing();
        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule